// File: doc/BRIEF.md
# CAN Controller Status Word

This block holds the read-only status byte of a CAN controller together with the buffer ownership logic that stands behind several of its bits. A transmit buffer is locked when the host requests a transmission and released when the protocol engine reports that the frame went out. A completion flag records whether the most recent request finished successfully. Two receive slots hold incoming messages. The host frees them one at a time, oldest first. A message that starts while both slots are occupied raises a sticky overrun flag and is thrown away. Bus-off, error-warning, transmit-activity and receive-activity flags are taken from engine inputs and from the two error counters.

The host reads the byte on `stat_word` at any time. All status inputs and host commands are single-cycle strobes or plain levels. No data stream passes through the block, so it has no valid/ready interface and applies no back-pressure. Every flag is registered, so each bit reflects the inputs of the previous clock cycle.

Top module: `can_status_unit`

## Requirements
- R1: `stat_word` bit 7 is bus-off, bit 6 is error warning, bit 5 is transmitting, bit 4 is receiving, bit 3 is transmit complete, bit 2 is transmit buffer released, bit 1 is data overrun and bit 0 is receive buffer full. While reset is held and after reset, the word reads 8'b0000_1100.
- R2: Bits 7, 5 and 4 equal the `bus_off`, `eng_tx_active` and `eng_rx_active` inputs as sampled at the previous rising clock edge.
- R3: Bit 6 is 1 one cycle after either `tx_err_cnt` or `rx_err_cnt` is greater than or equal to WARN_LIMIT (default 96). It is 0 when both counters are below that limit.
- R4: A `host_tx_req` pulse while bit 2 is 1 clears both bit 2 and bit 3 in the next cycle.
- R5: An `eng_tx_ok` pulse while bit 2 is 0 sets both bit 2 and bit 3 in the next cycle. An `eng_tx_ok` pulse while bit 2 is 1 changes neither bit.
- R6: A `host_tx_req` pulse while bit 2 is 0 is ignored: bits 3 and 2 keep their values.
- R7: Each `eng_rx_done` pulse stores a message in a free slot, and bit 0 is set in the next cycle. A `host_rel_rx` pulse frees the oldest slot. Bit 0 stays 1 while a slot still holds a message and falls to 0 once both slots are empty.
- R8: An `eng_rx_sof` pulse while both slots hold messages sets bit 1. That incoming message is discarded, so exactly two releases empty the slots.
- R9: `host_clr_ovr` clears bit 1. When it coincides with an overrun event, bit 1 stays set. A release that coincides with a stored message leaves bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_tx_req | input | 1 | Host command pulse: request transmission |
| host_rel_rx | input | 1 | Host command pulse: release oldest receive slot |
| host_clr_ovr | input | 1 | Host command pulse: clear overrun flag |
| eng_tx_ok | input | 1 | Engine pulse: transmission completed successfully |
| eng_rx_sof | input | 1 | Engine pulse: first byte of an incoming message |
| eng_rx_done | input | 1 | Engine pulse: incoming message complete |
| eng_tx_active | input | 1 | Engine level: transmitting |
| eng_rx_active | input | 1 | Engine level: receiving |
| bus_off | input | 1 | Level: controller is bus-off |
| tx_err_cnt | input | 8 | Transmit error counter |
| rx_err_cnt | input | 8 | Receive error counter |
| stat_word | output | 8 | Status word for host reads |

## Verification
The hardest condition to reach is an overrun together with its discarded message. The internal occupancy is not visible, so the only proof that nothing was stored is the number of releases it takes to empty the slots. The stimulus fills both slots, starts and finishes a third message, and then releases one slot at a time, checking bit 0 after each release. Coincident strobes are also driven deliberately to test the tie-break rules: clear-overrun with start-of-message, and release with message-done. The error-warning threshold is swept exhaustively over both counters.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;
  // Field order sets bit position: first member is bit 7.
  typedef struct packed {
    logic bus_off;
    logic err_warn;
    logic tx_busy;
    logic rx_busy;
    logic tx_done;
    logic tx_free;
    logic rx_ovr;
    logic rx_full;
  } stat_t;

  localparam int CNT_W_DEF  = 8;
  localparam int WARN_DEF   = 96;
  localparam int RX_SLOTS   = 2;
endpackage

// File: rtl/can_stat_warn.sv
module can_stat_warn #(
  parameter int N_CNT = 2,
  parameter int CNT_W = 8,
  parameter int LIMIT = 96
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_CNT-1:0][CNT_W-1:0] cnt,
  output logic                        warn
);
  localparam logic [CNT_W:0] LIM = LIMIT[CNT_W:0];

  logic [N_CNT-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < N_CNT; gi++) begin : g_cmp
      assign hit[gi] = ({1'b0, cnt[gi]} >= LIM);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) warn <= 1'b0;
    else        warn <= |hit;
  end
endmodule

// File: rtl/can_stat_txbuf.sv
module can_stat_txbuf (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic ok,
  output logic released,
  output logic complete
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      complete <= 1'b1;
    end else if (!pend_q) begin
      if (req) begin
        pend_q   <= 1'b1;
        complete <= 1'b0;
      end
    end else if (ok) begin
      pend_q   <= 1'b0;
      complete <= 1'b1;
    end
  end

  assign released = !pend_q;
endmodule

// File: rtl/can_stat_rxbuf.sv
module can_stat_rxbuf #(
  parameter int DEPTH = 2,
  localparam int OW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sof,
  input  logic          done,
  input  logic          rel,
  input  logic          clr_ovr,
  output logic [OW-1:0] occ,
  output logic          full_flag,
  output logic          ovr
);
  localparam logic [OW-1:0] TOP = DEPTH[OW-1:0];
  localparam logic [OW-1:0] ONE = {{(OW-1){1'b0}}, 1'b1};

  logic drop_q;
  logic is_full, set_ovr, store, take;
  logic [OW-1:0] occ_nxt;

  assign is_full = (occ == TOP);
  assign set_ovr = sof && is_full;
  assign store   = done && !drop_q && (!is_full || rel);
  assign take    = rel && (occ != '0);

  always_comb begin
    occ_nxt = occ;
    if (store && !take)      occ_nxt = occ + ONE;
    else if (take && !store) occ_nxt = occ - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ    <= '0;
      drop_q <= 1'b0;
      ovr    <= 1'b0;
    end else begin
      occ <= occ_nxt;
      if (sof)       drop_q <= is_full;
      else if (done) drop_q <= 1'b0;
      if (set_ovr)      ovr <= 1'b1;
      else if (clr_ovr) ovr <= 1'b0;
    end
  end

  assign full_flag = (occ != '0);
endmodule

// File: rtl/can_status_unit.sv
module can_status_unit #(
  parameter int CNT_W      = can_stat_pkg::CNT_W_DEF,
  parameter int WARN_LIMIT = can_stat_pkg::WARN_DEF,
  parameter int RX_DEPTH   = can_stat_pkg::RX_SLOTS,
  localparam int OCC_W     = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_tx_req,
  input  logic             host_rel_rx,
  input  logic             host_clr_ovr,
  input  logic             eng_tx_ok,
  input  logic             eng_rx_sof,
  input  logic             eng_rx_done,
  input  logic             eng_tx_active,
  input  logic             eng_rx_active,
  input  logic             bus_off,
  input  logic [CNT_W-1:0] tx_err_cnt,
  input  logic [CNT_W-1:0] rx_err_cnt,
  output logic [7:0]       stat_word
);
  import can_stat_pkg::*;

  stat_t             st;
  logic              bs_q, ts_q, rs_q, warn;
  logic              tx_free, tx_done, rx_full, rx_ovr;
  logic [OCC_W-1:0]  rx_occ;
  logic [1:0][CNT_W-1:0] cnts;

  assign cnts = {tx_err_cnt, rx_err_cnt};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bs_q <= 1'b0;
      ts_q <= 1'b0;
      rs_q <= 1'b0;
    end else begin
      bs_q <= bus_off;
      ts_q <= eng_tx_active;
      rs_q <= eng_rx_active;
    end
  end

  can_stat_warn #(.N_CNT(2), .CNT_W(CNT_W), .LIMIT(WARN_LIMIT)) u_warn (
    .clk(clk), .rst_n(rst_n), .cnt(cnts), .warn(warn)
  );

  can_stat_txbuf u_tx (
    .clk(clk), .rst_n(rst_n), .req(host_tx_req), .ok(eng_tx_ok),
    .released(tx_free), .complete(tx_done)
  );

  can_stat_rxbuf #(.DEPTH(RX_DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .sof(eng_rx_sof), .done(eng_rx_done),
    .rel(host_rel_rx), .clr_ovr(host_clr_ovr), .occ(rx_occ),
    .full_flag(rx_full), .ovr(rx_ovr)
  );

  always_comb begin
    st.bus_off  = bs_q;
    st.err_warn = warn;
    st.tx_busy  = ts_q;
    st.rx_busy  = rs_q;
    st.tx_done  = tx_done;
    st.tx_free  = tx_free;
    st.rx_ovr   = rx_ovr;
    st.rx_full  = rx_full;
  end

  assign stat_word = st;
endmodule

// File: rtl/can_status_unit_chk.sv
module can_status_unit_chk #(
  parameter int CNT_W = 8,
  parameter int LIMIT = 96,
  parameter int DEPTH = 2,
  parameter int OW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_tx_req,
  input logic             host_rel_rx,
  input logic             host_clr_ovr,
  input logic             eng_tx_ok,
  input logic             eng_rx_sof,
  input logic             bus_off,
  input logic [CNT_W-1:0] tx_err_cnt,
  input logic [CNT_W-1:0] rx_err_cnt,
  input logic [OW-1:0]    rx_occ,
  input logic [7:0]       stat_word
);
  logic pv;
  always_ff @(posedge clk) begin
    if (!rst_n) pv <= 1'b0;
    else        pv <= 1'b1;
  end

  a_r2_bs_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pv |-> stat_word[7] == $past(bus_off));

  a_r3_warn: assert property (@(posedge clk) disable iff (!rst_n)
    pv |-> stat_word[6] == (({1'b0, $past(tx_err_cnt)} >= LIMIT[CNT_W:0]) ||
                            ({1'b0, $past(rx_err_cnt)} >= LIMIT[CNT_W:0])));

  a_r4_lock: assert property (@(posedge clk) disable iff (!rst_n)
    host_tx_req && stat_word[2] |=> !stat_word[2] && !stat_word[3]);

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    eng_tx_ok && !stat_word[2] |=> stat_word[2] && stat_word[3]);

  a_r6_req_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    host_tx_req && !stat_word[2] && !eng_tx_ok |=> $stable(stat_word[3:2]));

  a_r7_rbs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[0] && !host_rel_rx |=> stat_word[0]);

  a_r8_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rx_sof && rx_occ == DEPTH[OW-1:0] |=> stat_word[1]);

  a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[1] && !host_clr_ovr |=> stat_word[1]);

  a_r8_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_occ <= DEPTH[OW-1:0]);
endmodule

bind can_status_unit can_status_unit_chk #(
  .CNT_W(CNT_W), .LIMIT(WARN_LIMIT), .DEPTH(RX_DEPTH), .OW(OCC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_tx_req(host_tx_req),
  .host_rel_rx(host_rel_rx), .host_clr_ovr(host_clr_ovr),
  .eng_tx_ok(eng_tx_ok), .eng_rx_sof(eng_rx_sof), .bus_off(bus_off),
  .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt), .rx_occ(rx_occ),
  .stat_word(stat_word)
);

// File: tb/can_status_unit_bench.sv
module can_status_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_req = 0, rel_rx = 0, clr_ovr = 0, tx_ok = 0, rx_sof = 0, rx_done = 0;
  logic tx_act = 0, rx_act = 0, boff = 0;
  logic [7:0] tcnt = 0, rcnt = 0;
  logic [7:0] sw;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  can_status_unit u_can_status_unit (
    .clk(clk), .rst_n(rst_n), .host_tx_req(tx_req), .host_rel_rx(rel_rx),
    .host_clr_ovr(clr_ovr), .eng_tx_ok(tx_ok), .eng_rx_sof(rx_sof),
    .eng_rx_done(rx_done), .eng_tx_active(tx_act), .eng_rx_active(rx_act),
    .bus_off(boff), .tx_err_cnt(tcnt), .rx_err_cnt(rcnt), .stat_word(sw)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // Strobes are set by the caller at a negedge; one clock later they are cleared.
  task automatic step();
    @(negedge clk);
    tx_req = 0; rel_rx = 0; clr_ovr = 0; tx_ok = 0; rx_sof = 0; rx_done = 0;
  endtask

  task automatic rx_msg();
    rx_sof = 1; step();
    rx_done = 1; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset held", sw, 8'b0000_1100);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", sw, 8'b0000_1100);

    // R2: all level combinations
    for (int i = 0; i < 8; i++) begin
      boff = i[2]; tx_act = i[1]; rx_act = i[0];
      @(negedge clk);
      chk("R2 levels", sw & 8'hB0, {i[2], 1'b0, i[1], i[0], 4'b0});
    end
    boff = 0; tx_act = 0; rx_act = 0;

    // R3: exhaustive sweep of each counter, plus a cross grid at the edge
    for (int v = 0; v < 256; v++) begin
      tcnt = v[7:0]; rcnt = 0;
      @(negedge clk);
      chk("R3 tx sweep", {7'b0, sw[6]}, {7'b0, (v >= 96)});
    end
    for (int v = 0; v < 256; v++) begin
      tcnt = 0; rcnt = v[7:0];
      @(negedge clk);
      chk("R3 rx sweep", {7'b0, sw[6]}, {7'b0, (v >= 96)});
    end
    for (int a = 94; a < 98; a++) begin
      for (int b = 94; b < 98; b++) begin
        tcnt = a[7:0]; rcnt = b[7:0];
        @(negedge clk);
        chk("R3 cross", {7'b0, sw[6]}, {7'b0, (a >= 96 || b >= 96)});
      end
    end
    tcnt = 0; rcnt = 0;
    @(negedge clk);

    // R5: success while released has no effect
    tx_ok = 1; step();
    chk("R5 ok while free", sw & 8'h0C, 8'h0C);
    // R4: request locks
    tx_req = 1; step();
    chk("R4 lock", sw & 8'h0C, 8'h00);
    // R6: request while locked ignored
    tx_req = 1; step();
    chk("R6 ignored", sw & 8'h0C, 8'h00);
    @(negedge clk);
    chk("R6 still locked", sw & 8'h0C, 8'h00);
    // R5: success releases
    tx_ok = 1; step();
    chk("R5 complete", sw & 8'h0C, 8'h0C);
    // second round
    tx_req = 1; step();
    chk("R4 relock", sw & 8'h0C, 8'h00);
    tx_ok = 1; step();
    chk("R5 complete again", sw & 8'h0C, 8'h0C);

    // R7: two-deep storage, release oldest
    chk("R7 empty", sw & 8'h03, 8'h00);
    rx_msg();
    chk("R7 one stored", sw & 8'h03, 8'h01);
    rx_msg();
    chk("R7 two stored", sw & 8'h03, 8'h01);
    rel_rx = 1; step();
    chk("R7 one left", sw & 8'h03, 8'h01);
    rel_rx = 1; step();
    chk("R7 emptied", sw & 8'h03, 8'h00);
    rel_rx = 1; step();
    chk("R7 release empty", sw & 8'h03, 8'h00);

    // R8: overrun and discard
    rx_msg(); rx_msg();
    rx_sof = 1; step();
    chk("R8 overrun set", sw & 8'h03, 8'h03);
    rx_done = 1; step();
    chk("R8 still set", sw & 8'h03, 8'h03);
    rel_rx = 1; step();
    chk("R8 one left", sw & 8'h01, 8'h01);
    rel_rx = 1; step();
    chk("R8 discarded msg not kept", sw & 8'h01, 8'h00);

    // R9: clear overrun
    clr_ovr = 1; step();
    chk("R9 clear", sw & 8'h02, 8'h00);
    rx_msg(); rx_msg();
    rx_sof = 1; clr_ovr = 1; step();
    chk("R9 set wins", sw & 8'h02, 8'h02);
    rx_done = 1; step();
    clr_ovr = 1; step();
    chk("R9 cleared later", sw & 8'h02, 8'h00);
    rel_rx = 1; step();
    rel_rx = 1; step();
    chk("R9 empty", sw & 8'h01, 8'h00);
    rx_msg();
    rx_sof = 1; step();
    rx_done = 1; rel_rx = 1; step();
    chk("R9 release+store keeps RBS", sw & 8'h01, 8'h01);
    rel_rx = 1; step();
    chk("R9 one held only", sw & 8'h01, 8'h00);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule